// File: doc/BRIEF.md
# Windowed Neuron Layer Engine

This block evaluates one layer of a two-dimensional feed-forward perceptron. The source layer is a grid of SRC_X by SRC_Y activations and the destination layer is a grid of DST_X by DST_Y neurons. Along each axis, destination neuron i reads a window of G source neurons. The window starts at i times S, where S is the step along that axis. Windows may overlap. An axis with step 0 and a window as wide as the axis is fully connected, so the same datapath runs both ordinary dense layers and partially connected layers.

Software loads the source activations and the weights through two write ports, then pulses `start`. The engine visits the connected sources of each destination neuron and performs one signed multiply-accumulate per clock. It writes each saturated pre-activation sum into a result buffer, pulses `done` at the end, and reports the index of the largest sum. The activation nonlinearity and training are left to other logic.

Top module: `pcl_layer_engine`

## Requirements
- R1: After reset, `done` is low, `win_idx` is 0 and every result buffer entry reads 0.
- R2: Destination neuron (x,y) sums over every source (sx,sy) with x*SX <= sx <= x*SX+GX-1 and y*SY <= sy <= y*SY+GY-1, and over no other source (default 10-wide X axis, window 4, step 2; Y axis of 22 fully connected).
- R3: An axis with step 0 and a window equal to its size connects every destination neuron to every source along that axis.
- R4: Source activation (sx,sy) lives at buffer address sx*SRC_Y+sy. The weight of window offset (ox,oy) for destination (x,y) lives at address ((x*DST_Y+y)*GX+ox)*GY+oy. The result of (x,y) is read at address x*DST_Y+y.
- R5: Activations and weights are two's complement, and each sum is the exact signed total of weight times activation over the window, with no overflow inside the accumulator.
- R6: A sum above 2^(OUT_W-1)-1 reads as 2^(OUT_W-1)-1, and a sum below -2^(OUT_W-1) reads as -2^(OUT_W-1).
- R7: One product is taken per clock. `done` is a one-cycle pulse that rises exactly DST_X*DST_Y*GX*GY+3 clock edges after the edge that samples `start`.
- R8: A `start` pulse that arrives while an evaluation is running has no effect on its timing or its results.
- R9: When `done` is high, `win_idx` holds the address of the largest result. On a tie it holds the lowest such address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_wr_en | input | 1 | Write strobe for the activation buffer |
| act_wr_addr | input | SRC_AW | Activation address, sx*SRC_Y+sy |
| act_wr_data | input | ACT_W | Signed activation |
| wgt_wr_en | input | 1 | Write strobe for the weight store |
| wgt_wr_addr | input | W_AW | Weight address (R4) |
| wgt_wr_data | input | WGT_W | Signed weight |
| start | input | 1 | Begins an evaluation when the engine is idle |
| done | output | 1 | One-cycle end-of-evaluation pulse |
| res_rd_addr | input | D_AW | Result address, x*DST_Y+y |
| res_rd_data | output | OUT_W | Saturated signed sum at that address |
| win_idx | output | D_AW | Address of the largest result |

## Verification
The bench runs two instances: the default overlapping-window layer and a small dense layer. It compares every sum against a reference model and loads random data several times. A walker that ignored the step, or that used the wrong window origin, would pick up neighbouring columns, and most sums would then differ. All-extreme operands drive each sum past both saturation limits, and one case pairs two negative operands. A design that wrapped instead of clamping, or that treated operands as unsigned, would show a wrong sign or magnitude. The bench also counts cycles to `done`, fires a second `start` in the middle of a run, and builds a tie between two neurons. These catch a stalled or restarted walk and a winner comparison that replaces on equality.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

   // Address width for a storage of n entries (minimum one bit)
   function automatic int pcl_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // Last source index touched along an axis, plus one
   function automatic int pcl_span(input int dst, input int grp, input int step);
      return (dst - 1) * step + grp;
   endfunction

   // Accumulator width that holds area full-scale products exactly
   function automatic int pcl_acc_bits(input int aw, input int ww, input int area);
      return aw + ww + $clog2(area + 1);
   endfunction

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;

endpackage

// File: rtl/pcl_addr_walk.sv
module pcl_addr_walk
   import pcl_pkg::*;
#(
   parameter int SRC_X  = 10,
   parameter int SRC_Y  = 22,
   parameter int DST_X  = 4,
   parameter int DST_Y  = 6,
   parameter int GX     = 4,
   parameter int SX     = 2,
   parameter int GY     = 22,
   parameter int SY     = 0,
   parameter int SRC_AW = 8,
   parameter int W_AW   = 12,
   parameter int D_AW   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              vld,
   output logic [SRC_AW-1:0] src_addr,
   output logic [W_AW-1:0]   w_addr,
   output logic [D_AW-1:0]   dst_idx,
   output logic              grp_first,
   output logic              grp_last,
   output logic              all_last
);

   localparam int XW    = pcl_bits(DST_X);
   localparam int YW    = pcl_bits(DST_Y);
   localparam int GXW   = pcl_bits(GX);
   localparam int GYW   = pcl_bits(GY);
   localparam int SRC_N = SRC_X * SRC_Y;
   localparam int W_N   = DST_X * DST_Y * GX * GY;

   walk_state_e      state;
   logic [XW-1:0]    ox;
   logic [YW-1:0]    oy;
   logic [GXW-1:0]   gxo;
   logic [GYW-1:0]   gyo;
   logic [W_AW-1:0]  wcnt;
   logic             l_gy, l_gx, l_oy, l_ox;
   int               src_x_i;
   int               src_y_i;

   assign l_gy = (gyo == GYW'(GY - 1));
   assign l_gx = (gxo == GXW'(GX - 1));
   assign l_oy = (oy  == YW'(DST_Y - 1));
   assign l_ox = (ox  == XW'(DST_X - 1));

   // Window origin per axis: a zero step means the axis is dense
   generate
      if (SX == 0) begin : g_x_dense
         assign src_x_i = int'(gxo);
      end else begin : g_x_window
         assign src_x_i = int'(ox) * SX + int'(gxo);
      end
      if (SY == 0) begin : g_y_dense
         assign src_y_i = int'(gyo);
      end else begin : g_y_window
         assign src_y_i = int'(oy) * SY + int'(gyo);
      end
   endgenerate

   assign vld       = (state == WALK_RUN);
   assign src_addr  = SRC_AW'(src_x_i * SRC_Y + src_y_i);
   assign w_addr    = wcnt;
   assign dst_idx   = D_AW'(int'(ox) * DST_Y + int'(oy));
   assign grp_first = (gxo == '0) && (gyo == '0);
   assign grp_last  = l_gx && l_gy;
   assign all_last  = l_gx && l_gy && l_oy && l_ox;

   // Innermost to outermost: Y offset, X offset, destination Y, destination X
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= WALK_IDLE;
         ox    <= '0;
         oy    <= '0;
         gxo   <= '0;
         gyo   <= '0;
         wcnt  <= '0;
      end else if (state == WALK_IDLE) begin
         if (start) begin
            state <= WALK_RUN;
            ox    <= '0;
            oy    <= '0;
            gxo   <= '0;
            gyo   <= '0;
            wcnt  <= '0;
         end
      end else begin
         wcnt <= wcnt + W_AW'(1);
         if (!l_gy) begin
            gyo <= gyo + GYW'(1);
         end else begin
            gyo <= '0;
            if (!l_gx) begin
               gxo <= gxo + GXW'(1);
            end else begin
               gxo <= '0;
               if (!l_oy) begin
                  oy <= oy + YW'(1);
               end else begin
                  oy <= '0;
                  if (!l_ox) begin
                     ox <= ox + XW'(1);
                  end else begin
                     state <= WALK_IDLE;
                  end
               end
            end
         end
      end
   end

   // R7 / R8: a running walk advances by exactly one weight per clock
   assert_one_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !all_last) |=> (vld && w_addr == $past(w_addr) + W_AW'(1)))
      else $error("walk did not advance one connection per clock");

   // R2: generated source addresses stay inside the activation buffer
   assert_src_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> (int'(src_addr) < SRC_N && int'(w_addr) < W_N))
      else $error("walk address out of range");

endmodule

// File: rtl/pcl_mac.sv
module pcl_mac #(
   parameter int ACT_W = 8,
   parameter int WGT_W = 8,
   parameter int OUT_W = 16,
   parameter int ACC_W = 23,
   parameter int AREA  = 88,
   parameter int D_AW  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic                    in_first,
   input  logic                    in_last,
   input  logic signed [ACT_W-1:0] in_act,
   input  logic signed [WGT_W-1:0] in_wgt,
   input  logic [D_AW-1:0]         in_dst,
   output logic                    sum_vld,
   output logic signed [OUT_W-1:0] sum_out,
   output logic [D_AW-1:0]         sum_dst
);

   localparam int PW = ACT_W + WGT_W;
   localparam logic signed [ACC_W-1:0] ACC_LIM = ACC_W'(AREA) << (PW - 2);

   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] acc, acc_next;
   logic signed [OUT_W-1:0] sat;

   assign prod     = in_act * in_wgt;
   assign acc_next = (in_first ? '0 : acc) + {{(ACC_W - PW){prod[PW-1]}}, prod};

   generate
      if (ACC_W > OUT_W) begin : g_clamp
         localparam logic signed [ACC_W-1:0] HI = {{(ACC_W - OUT_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}};
         localparam logic signed [ACC_W-1:0] LO = ~HI;
         always_comb begin
            if (acc_next > HI)      sat = HI[OUT_W-1:0];
            else if (acc_next < LO) sat = LO[OUT_W-1:0];
            else                    sat = acc_next[OUT_W-1:0];
         end
      end else begin : g_extend
         assign sat = OUT_W'(acc_next);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         sum_vld <= 1'b0;
         sum_out <= '0;
         sum_dst <= '0;
      end else begin
         sum_vld <= in_vld && in_last;
         if (in_vld) begin
            acc <= acc_next;
            if (in_last) begin
               sum_out <= sat;
               sum_dst <= in_dst;
            end
         end
      end
   end

   // R5: the running total never leaves the range of AREA full-scale products
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> (acc_next <= ACC_LIM && acc_next >= -ACC_LIM))
      else $error("accumulator beyond its exact range");

endmodule

// File: rtl/pcl_argmax.sv
module pcl_argmax #(
   parameter int OUT_W = 16,
   parameter int D_AW  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic signed [OUT_W-1:0] in_sum,
   input  logic [D_AW-1:0]         in_dst,
   output logic [D_AW-1:0]         win_idx
);

   logic signed [OUT_W-1:0] best;

   // The first neuron of a run seeds the search; later ones must be strictly larger
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best    <= '0;
         win_idx <= '0;
      end else if (in_vld && (in_dst == '0 || in_sum > best)) begin
         best    <= in_sum;
         win_idx <= in_dst;
      end
   end

   // R9: within one run the held maximum never drops
   assert_best_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_dst != '0) |=> (best >= $past(best)))
      else $error("winner value decreased within a run");

endmodule

// File: rtl/pcl_layer_engine.sv
module pcl_layer_engine
   import pcl_pkg::*;
#(
   parameter int SRC_X  = 10,
   parameter int SRC_Y  = 22,
   parameter int DST_X  = 4,
   parameter int DST_Y  = 6,
   parameter int GX     = 4,
   parameter int SX     = 2,
   parameter int GY     = 22,
   parameter int SY     = 0,
   parameter int ACT_W  = 8,
   parameter int WGT_W  = 8,
   parameter int OUT_W  = 16,
   localparam int SRC_N  = SRC_X * SRC_Y,
   localparam int AREA   = GX * GY,
   localparam int DST_N  = DST_X * DST_Y,
   localparam int W_N    = DST_N * AREA,
   localparam int SRC_AW = pcl_bits(SRC_N),
   localparam int W_AW   = pcl_bits(W_N),
   localparam int D_AW   = pcl_bits(DST_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_wr_en,
   input  logic [SRC_AW-1:0] act_wr_addr,
   input  logic [ACT_W-1:0]  act_wr_data,
   input  logic              wgt_wr_en,
   input  logic [W_AW-1:0]   wgt_wr_addr,
   input  logic [WGT_W-1:0]  wgt_wr_data,
   input  logic              start,
   output logic              done,
   input  logic [D_AW-1:0]   res_rd_addr,
   output logic [OUT_W-1:0]  res_rd_data,
   output logic [D_AW-1:0]   win_idx
);

   localparam int ACC_W = pcl_acc_bits(ACT_W, WGT_W, AREA);

   // Elaboration-time parameter checks
   generate
      if (GX < 1 || GY < 1 || SX < 0 || SY < 0) begin : g_bad_shape
         $error("window sizes must be positive and steps non-negative");
      end
      if (pcl_span(DST_X, GX, SX) > SRC_X) begin : g_bad_x
         $error("X windows run past the source layer");
      end
      if (pcl_span(DST_Y, GY, SY) > SRC_Y) begin : g_bad_y
         $error("Y windows run past the source layer");
      end
      if (OUT_W < 2 || ACT_W < 2 || WGT_W < 2) begin : g_bad_width
         $error("data widths must be at least two bits");
      end
   endgenerate

   logic [ACT_W-1:0]  act_mem [SRC_N];
   logic [WGT_W-1:0]  wgt_mem [W_N];
   logic [OUT_W-1:0]  res_mem [DST_N];

   logic              w_vld, w_first, w_last, w_fin;
   logic [SRC_AW-1:0] w_src;
   logic [W_AW-1:0]   w_wad;
   logic [D_AW-1:0]   w_dst;

   logic              s1_vld, s1_first, s1_last, s1_fin;
   logic [D_AW-1:0]   s1_dst;
   logic [ACT_W-1:0]  act_q;
   logic [WGT_W-1:0]  wgt_q;

   logic              m_vld;
   logic [OUT_W-1:0]  m_sum;
   logic [D_AW-1:0]   m_dst;
   logic              fin_q;

   pcl_addr_walk #(
      .SRC_X(SRC_X), .SRC_Y(SRC_Y), .DST_X(DST_X), .DST_Y(DST_Y),
      .GX(GX), .SX(SX), .GY(GY), .SY(SY),
      .SRC_AW(SRC_AW), .W_AW(W_AW), .D_AW(D_AW)
   ) walk_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .vld(w_vld), .src_addr(w_src), .w_addr(w_wad), .dst_idx(w_dst),
      .grp_first(w_first), .grp_last(w_last), .all_last(w_fin)
   );

   // Loading ports and registered reads of both operand stores
   always_ff @(posedge clk) begin
      if (act_wr_en) act_mem[act_wr_addr] <= act_wr_data;
      if (wgt_wr_en) wgt_mem[wgt_wr_addr] <= wgt_wr_data;
      act_q <= act_mem[w_src];
      wgt_q <= wgt_mem[w_wad];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld   <= 1'b0;
         s1_first <= 1'b0;
         s1_last  <= 1'b0;
         s1_fin   <= 1'b0;
         s1_dst   <= '0;
         fin_q    <= 1'b0;
      end else begin
         s1_vld   <= w_vld;
         s1_first <= w_first;
         s1_last  <= w_last;
         s1_fin   <= w_fin;
         s1_dst   <= w_dst;
         fin_q    <= s1_vld && s1_last && s1_fin;
      end
   end

   pcl_mac #(
      .ACT_W(ACT_W), .WGT_W(WGT_W), .OUT_W(OUT_W),
      .ACC_W(ACC_W), .AREA(AREA), .D_AW(D_AW)
   ) mac_i (
      .clk(clk), .rst_n(rst_n),
      .in_vld(s1_vld), .in_first(s1_first), .in_last(s1_last),
      .in_act(act_q), .in_wgt(wgt_q), .in_dst(s1_dst),
      .sum_vld(m_vld), .sum_out(m_sum), .sum_dst(m_dst)
   );

   pcl_argmax #(
      .OUT_W(OUT_W), .D_AW(D_AW)
   ) argmax_i (
      .clk(clk), .rst_n(rst_n),
      .in_vld(m_vld), .in_sum(m_sum), .in_dst(m_dst),
      .win_idx(win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         for (int i = 0; i < DST_N; i++) res_mem[i] <= '0;
      end else begin
         done <= m_vld && fin_q;
         if (m_vld) res_mem[m_dst] <= m_sum;
      end
   end

   assign res_rd_data = res_mem[res_rd_addr];

   // R7: completion is a single-cycle pulse
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done held for more than one cycle");

   // R7: completion is only signalled once the walk has stopped
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!w_vld && !s1_vld))
      else $error("done while products still in flight");

endmodule

// File: tb/pcl_layer_engine_tb_top.sv
module pcl_layer_engine_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // Instance A: 10(4,2) x 22 source, 4 x 6 destination
   logic        a_act_en = 0, a_wgt_en = 0, a_start = 0, a_done;
   logic [7:0]  a_act_addr = 0, a_act_data = 0, a_wgt_data = 0;
   logic [11:0] a_wgt_addr = 0;
   logic [4:0]  a_rd_addr = 0, a_win;
   logic [15:0] a_rd_data;

   // Instance B: dense 5 x 3 source, 2 x 2 destination
   logic        b_act_en = 0, b_wgt_en = 0, b_start = 0, b_done;
   logic [3:0]  b_act_addr = 0;
   logic [7:0]  b_act_data = 0, b_wgt_data = 0;
   logic [5:0]  b_wgt_addr = 0;
   logic [1:0]  b_rd_addr = 0, b_win;
   logic [15:0] b_rd_data;

   pcl_layer_engine dut_i (
      .clk(clk), .rst_n(rst_n),
      .act_wr_en(a_act_en), .act_wr_addr(a_act_addr), .act_wr_data(a_act_data),
      .wgt_wr_en(a_wgt_en), .wgt_wr_addr(a_wgt_addr), .wgt_wr_data(a_wgt_data),
      .start(a_start), .done(a_done),
      .res_rd_addr(a_rd_addr), .res_rd_data(a_rd_data), .win_idx(a_win)
   );

   pcl_layer_engine #(
      .SRC_X(5), .SRC_Y(3), .DST_X(2), .DST_Y(2),
      .GX(5), .SX(0), .GY(3), .SY(0)
   ) dut_full_i (
      .clk(clk), .rst_n(rst_n),
      .act_wr_en(b_act_en), .act_wr_addr(b_act_addr), .act_wr_data(b_act_data),
      .wgt_wr_en(b_wgt_en), .wgt_wr_addr(b_wgt_addr), .wgt_wr_data(b_wgt_data),
      .start(b_start), .done(b_done),
      .res_rd_addr(b_rd_addr), .res_rd_data(b_rd_data), .win_idx(b_win)
   );

   int act_a [220];
   int wgt_a [2112];
   int act_b [15];
   int wgt_b [60];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int sat16(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   // R2 R4 R5 R6: windowed reference for instance A (X step 2, Y dense)
   function automatic int ref_a(input int x, input int y);
      longint acc = 0;
      for (int ox = 0; ox < 4; ox++)
         for (int oy = 0; oy < 22; oy++)
            acc += longint'(act_a[(x * 2 + ox) * 22 + oy]) *
                   longint'(wgt_a[((x * 6 + y) * 4 + ox) * 22 + oy]);
      return sat16(acc);
   endfunction

   // R3 R4 R5: dense reference for instance B
   function automatic int ref_b(input int x, input int y);
      longint acc = 0;
      for (int ox = 0; ox < 5; ox++)
         for (int oy = 0; oy < 3; oy++)
            acc += longint'(act_b[ox * 3 + oy]) *
                   longint'(wgt_b[((x * 2 + y) * 5 + ox) * 3 + oy]);
      return sat16(acc);
   endfunction

   function automatic int rnd8();
      return int'($urandom_range(255)) - 128;
   endfunction

   // mode 0 random, 1 +max*+max, 2 +max*min, 3 min*min, 4 tie at 2 and 5
   task automatic fill_a(input int mode);
      for (int i = 0; i < 220; i++)
         act_a[i] = (mode == 0) ? rnd8() : (mode == 3) ? -128 : (mode == 4) ? 1 : 127;
      for (int i = 0; i < 2112; i++)
         wgt_a[i] = (mode == 0) ? rnd8() : (mode == 1) ? 127 : (mode == 4) ? 0 : -128;
      if (mode == 4) begin
         wgt_a[2 * 88] = 3;
         wgt_a[5 * 88 + 40] = 3;
         wgt_a[9 * 88 + 7] = -5;
      end
   endtask

   task automatic load_a();
      for (int i = 0; i < 220; i++) begin
         @(negedge clk);
         a_act_en = 1; a_act_addr = 8'(i); a_act_data = 8'(act_a[i]);
      end
      @(negedge clk) a_act_en = 0;
      for (int i = 0; i < 2112; i++) begin
         @(negedge clk);
         a_wgt_en = 1; a_wgt_addr = 12'(i); a_wgt_data = 8'(wgt_a[i]);
      end
      @(negedge clk) a_wgt_en = 0;
   endtask

   task automatic load_b();
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         b_act_en = 1; b_act_addr = 4'(i); b_act_data = 8'(act_b[i]);
      end
      @(negedge clk) b_act_en = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         b_wgt_en = 1; b_wgt_addr = 6'(i); b_wgt_data = 8'(wgt_b[i]);
      end
      @(negedge clk) b_wgt_en = 0;
   endtask

   task automatic run_a(input bit restart, input string tag);
      int n = 0;
      int best = 0;
      int best_i = 0;
      @(negedge clk) a_start = 1;
      while (n < 5000) begin
         @(posedge clk); n++;
         #1;
         if (n == 1) a_start = 0;
         if (restart && n == 50) a_start = 1;
         if (restart && n == 51) a_start = 0;
         if (a_done) break;
      end
      chk(n == 2115, {"R7 R8 latency ", tag}, n, 2115);
      for (int d = 0; d < 24; d++) begin
         int exp = ref_a(d / 6, d % 6);
         int got;
         a_rd_addr = 5'(d); #1;
         got = int'($signed(a_rd_data));
         chk(got == exp, {"R2 R4 R5 R6 sum ", tag}, got, exp);
         if (d == 0 || exp > best) begin best = exp; best_i = d; end
      end
      chk(int'(a_win) == best_i, {"R9 winner ", tag}, int'(a_win), best_i);
      @(posedge clk); #1;
      chk(a_done == 1'b0, {"R7 single pulse ", tag}, int'(a_done), 0);
   endtask

   task automatic run_b(input string tag);
      int n = 0;
      int best = 0;
      int best_i = 0;
      @(negedge clk) b_start = 1;
      while (n < 500) begin
         @(posedge clk); n++;
         #1;
         if (n == 1) b_start = 0;
         if (b_done) break;
      end
      chk(n == 63, {"R7 latency ", tag}, n, 63);
      for (int d = 0; d < 4; d++) begin
         int exp = ref_b(d / 2, d % 2);
         int got;
         b_rd_addr = 2'(d); #1;
         got = int'($signed(b_rd_data));
         chk(got == exp, {"R3 R4 R5 dense sum ", tag}, got, exp);
         if (d == 0 || exp > best) begin best = exp; best_i = d; end
      end
      chk(int'(b_win) == best_i, {"R9 dense winner ", tag}, int'(b_win), best_i);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(a_done == 1'b0, "R1 done low", int'(a_done), 0);
      chk(a_win == '0, "R1 winner zero", int'(a_win), 0);
      for (int d = 0; d < 24; d++) begin
         a_rd_addr = 5'(d); #1;
         chk(a_rd_data == '0, "R1 result zero", int'(a_rd_data), 0);
      end
      rst_n = 1;
      repeat (2) @(negedge clk);

      for (int r = 0; r < 3; r++) begin
         fill_a(0); load_a(); run_a(r == 2, "random");
      end
      fill_a(1); load_a(); run_a(0, "pos clamp");
      fill_a(2); load_a(); run_a(0, "neg clamp");
      fill_a(3); load_a(); run_a(0, "neg times neg");
      fill_a(4); load_a(); run_a(1, "tie");
      chk(int'(a_win) == 2, "R9 tie lowest index", int'(a_win), 2);

      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < 15; i++) act_b[i] = rnd8();
         for (int i = 0; i < 60; i++) wgt_b[i] = rnd8();
         load_b(); run_b("random");
      end
      for (int i = 0; i < 15; i++) act_b[i] = -128;
      for (int i = 0; i < 60; i++) wgt_b[i] = (i < 30) ? 127 : -128;
      load_b(); run_b("extreme");

      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog R7 actual %0d expected %0d", 200000, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule